// File: doc/BRIEF.md
# Conditional Microcode Sequencer With Opcode Mapping

This block is the control half of a microprogrammed processor. A control address register points into a 32-word internal control store of horizontal microwords. Each microword holds one bit per control line, a two-bit condition selector, a three-bit sequencing operation and a branch target. A control buffer register holds the microword that is currently executing and drives the control lines directly. In every clock the sequencer picks the next microaddress, reads that word from the store, and loads both registers on the same edge.

The next microaddress comes from one of these sources: the current address plus one, the word's branch target (unconditionally or under a flag test), a routine address derived from the instruction opcode, a single-level subroutine call and return, or an interrupt vector that is taken only while an interrupt request is pending. The built-in microprogram contains the following routines. Fetch: word 1 branches to 4 if the indirect bit is set, word 3 jumps to 5, word 5 tests for interrupts (vector 12), word 6 maps the opcode. Subroutine: word 9 returns. Interrupt: word 12 calls 8, word 14 jumps to 0. Opcode k runs at 16+2k and its second word jumps to 0; the first words are: k0 branch to 0 on zero, k1 branch to 0 on overflow, k2 call 8, k3 return, k4 interrupt test, k5 map, k6 an unused code 6, k7 continue (and word 31 continues, wrapping to 0). Word 0 is all zero, and every word not listed continues.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, `uaddr` is 0 and every control line is 0.
- R2: `ctrl` always equals the control bits of the word at `uaddr`; the control bits of word a are the low 16 bits of a × 0x451, so word 0 drives all lines low.
- R3: Sequencing code 0 (continue), and the unused codes 6 and 7, move to `uaddr`+1 modulo 32.
- R4: Code 1 is a conditional branch; condition 0 is always true, 1 is `flag_z`, 2 is `flag_v`, 3 is `ind_bit`; true goes to the target, false to `uaddr`+1.
- R5: Code 2 maps the opcode: the next address is 16 + 2 × `opcode`.
- R6: Code 3 is a call: it goes to the target and saves `uaddr`+1 as the return address.
- R7: Code 4 is a return: it goes to the saved address and forgets it; with no call outstanding it goes to 0.
- R8: Code 5 is an interrupt test: with `irq` high it goes to address 12, otherwise to `uaddr`+1.
- R9: Inputs are sampled at the edge that ends a microword, and the new `uaddr` and its `ctrl` appear together right after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 3 | Instruction-register opcode used by the map operation |
| flag_z | input | 1 | ALU zero flag |
| flag_v | input | 1 | ALU overflow flag |
| ind_bit | input | 1 | Indirect-address bit of the current instruction |
| irq | input | 1 | Pending interrupt request |
| ctrl | output | 16 | Control lines from the buffer register |
| uaddr | output | 5 | Current microaddress |

## Verification
The bench builds the block with its default widths: 16 control lines, a 5-bit microaddress and a 3-bit opcode. With these values the store has only 32 words, so random opcodes, flags and interrupt requests reach every routine, both outcomes of every flag test, a call that returns, a return with nothing saved, and the wrap from word 31 to word 0 within a few thousand cycles. A reference model of the sequencing rules predicts every address and control word, and a reset in the middle of a routine is added as a directed case.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int CTRL_W     = 16,
  parameter int AW         = 5,
  parameter int OP_W       = 3,
  parameter int MAP_BASE   = 16,
  parameter int MAP_STRIDE = 2,
  parameter int INT_VEC    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              ind_bit,
  input  logic              irq,
  output logic [CTRL_W-1:0] ctrl,
  output logic [AW-1:0]     uaddr
);

  localparam int WW = CTRL_W + 2 + 3 + AW;
  localparam logic [2:0] OP_NEXT = 3'd0, OP_BR  = 3'd1, OP_MAP = 3'd2,
                         OP_CALL = 3'd3, OP_RET = 3'd4, OP_IRQ = 3'd5;

  function automatic logic [WW-1:0] uword(input logic [AW-1:0] a);
    logic [2:0]    op;
    logic [1:0]    cs;
    logic [AW-1:0] tg;
    op = OP_NEXT;
    cs = 2'd0;
    tg = '0;
    case (int'(a))
      1:  begin op = OP_BR;   cs = 2'd3; tg = AW'(4); end
      3:  begin op = OP_BR;   cs = 2'd0; tg = AW'(5); end
      5:  op = OP_IRQ;
      6:  op = OP_MAP;
      9:  op = OP_RET;
      12: begin op = OP_CALL; tg = AW'(8); end
      14: begin op = OP_BR;   cs = 2'd0; tg = '0; end
      16: begin op = OP_BR;   cs = 2'd1; tg = '0; end
      18: begin op = OP_BR;   cs = 2'd2; tg = '0; end
      20: begin op = OP_CALL; tg = AW'(8); end
      22: op = OP_RET;
      24: op = OP_IRQ;
      26: op = OP_MAP;
      28: op = 3'd6;
      17, 19, 21, 23, 25, 27, 29: begin op = OP_BR; cs = 2'd0; tg = '0; end
      default: op = OP_NEXT;
    endcase
    uword = {tg, op, cs, CTRL_W'(32'(a) * 32'h451)};
  endfunction

  logic [AW-1:0] car, nxt, inc, ret_addr;
  logic [WW-1:0] cbr;
  logic          ret_vld, cond_ok;
  logic [1:0]    w_cs;
  logic [2:0]    w_op;
  logic [AW-1:0] w_tg;

  assign w_cs  = cbr[CTRL_W +: 2];
  assign w_op  = cbr[CTRL_W+2 +: 3];
  assign w_tg  = cbr[CTRL_W+5 +: AW];
  assign inc   = car + AW'(1);
  assign ctrl  = cbr[CTRL_W-1:0];
  assign uaddr = car;

  always_comb begin
    case (w_cs)
      2'd0:    cond_ok = 1'b1;
      2'd1:    cond_ok = flag_z;
      2'd2:    cond_ok = flag_v;
      default: cond_ok = ind_bit;
    endcase
  end

  always_comb begin
    case (w_op)
      OP_BR:   nxt = cond_ok ? w_tg : inc;
      OP_MAP:  nxt = AW'(MAP_BASE) + AW'(opcode) * AW'(MAP_STRIDE);
      OP_CALL: nxt = w_tg;
      OP_RET:  nxt = ret_vld ? ret_addr : '0;
      OP_IRQ:  nxt = irq ? AW'(INT_VEC) : inc;
      default: nxt = inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car      <= '0;
      cbr      <= '0;
      ret_addr <= '0;
      ret_vld  <= 1'b0;
    end else begin
      car <= nxt;
      cbr <= uword(nxt);
      if (w_op == OP_CALL) begin
        ret_addr <= inc;
        ret_vld  <= 1'b1;
      end else if (w_op == OP_RET) begin
        ret_vld  <= 1'b0;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (uaddr == '0 && ctrl == '0));

  p_continue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_op == OP_NEXT) |=> (uaddr == $past(uaddr) + AW'(1)));

  p_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_op == OP_MAP) |=> (uaddr == AW'(MAP_BASE) + AW'($past(opcode)) * AW'(MAP_STRIDE)));

  p_call_saves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_op == OP_CALL) |=> (ret_vld && ret_addr == $past(uaddr) + AW'(1)));

  p_empty_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_op == OP_RET && !ret_vld) |=> (uaddr == '0));

  p_irq_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_op == OP_IRQ && irq) |=> (uaddr == AW'(INT_VEC)));

endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  opcode = '0;
  logic        flag_z = 1'b0, flag_v = 1'b0, ind_bit = 1'b0, irq = 1'b0;
  logic [15:0] ctrl;
  logic [4:0]  uaddr;

  int compared = 0, mismatched = 0;
  int m_car = 0, m_ret = 0;
  bit m_vld = 1'b0;

  always #10 clk = ~clk;

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .flag_z(flag_z), .flag_v(flag_v),
    .ind_bit(ind_bit), .irq(irq), .ctrl(ctrl), .uaddr(uaddr)
  );

  function automatic int exp_ctrl(input int a);
    return (a * 32'h451) & 32'hFFFF;
  endfunction

  // program from the brief: returns {op, cond, target}
  function automatic void prog(input int a, output int op, output int cs, output int tg);
    op = 0; cs = 0; tg = 0;
    if (a >= 16 && a[0]) begin op = 1; return; end
    case (a)
      1:  begin op = 1; cs = 3; tg = 4; end
      3:  begin op = 1; tg = 5; end
      5:  op = 5;
      6:  op = 2;
      9:  op = 4;
      12: begin op = 3; tg = 8; end
      14: op = 1;
      16: begin op = 1; cs = 1; end
      18: begin op = 1; cs = 2; end
      20: begin op = 3; tg = 8; end
      22: op = 4;
      24: op = 5;
      26: op = 2;
      28: op = 6;
      default: op = 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (at model addr %0d)", tag, act, exp, m_car);
    end
  endtask

  task automatic step();
    int op, cs, tg, inc, nxt;
    bit c;
    string tag;
    prog(m_car, op, cs, tg);
    inc = (m_car + 1) % 32;
    case (op)
      1: begin
        c = (cs == 0) ? 1'b1 : (cs == 1) ? flag_z : (cs == 2) ? flag_v : ind_bit;
        nxt = c ? tg : inc; tag = "R4";
      end
      2: begin nxt = 16 + 2 * int'(opcode); tag = "R5"; end
      3: begin nxt = tg; m_ret = inc; m_vld = 1'b1; tag = "R6"; end
      4: begin nxt = m_vld ? m_ret : 0; m_vld = 1'b0; tag = "R7"; end
      5: begin nxt = irq ? 12 : inc; tag = "R8"; end
      default: begin nxt = inc; tag = "R3"; end
    endcase
    @(posedge clk);
    @(negedge clk);
    m_car = nxt;
    check(tag, int'(uaddr), nxt);
    check("R2/R9", int'(ctrl), exp_ctrl(nxt));
  endtask

  task automatic randomize_inputs();
    opcode  = 3'($urandom);
    flag_z  = 1'($urandom);
    flag_v  = 1'($urandom);
    ind_bit = 1'($urandom);
    irq     = ($urandom % 4) == 0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(uaddr), 0);
    check("R1", int'(ctrl), 0);
    rst_n = 1'b1;
    m_car = 0; m_vld = 1'b0;

    // directed: fetch with indirect set, no irq, opcode 3 -> empty return
    ind_bit = 1'b1; irq = 1'b0; opcode = 3'd3;
    repeat (10) step();
    // directed: opcode 7 runs off the end and wraps
    ind_bit = 1'b0; opcode = 3'd7;
    repeat (12) step();
    // directed: interrupt taken, call/return inside handler
    irq = 1'b1;
    repeat (12) step();

    for (int i = 0; i < 4000; i++) begin
      randomize_inputs();
      step();
    end

    // mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(uaddr), 0);
    check("R1", int'(ctrl), 0);
    rst_n = 1'b1;
    m_car = 0; m_vld = 1'b0;
    for (int i = 0; i < 500; i++) begin
      randomize_inputs();
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule